// File: doc/BRIEF.md
# Receive Idle Timeout Counter

This block tells a host that received characters are sitting unread. It holds two independent timers. The first is a fixed watchdog. It counts bit-time ticks and raises a flag once 64 bit times pass with no character entering the receive FIFO and no FIFO read. The second is a programmable 16-bit countdown. In idle-timeout mode, receive activity retriggers this countdown. It raises a ready flag when the line has been quiet for longer than the programmed interval.

In idle-timeout mode, every character transfer into the FIFO starts a fixed sequence. The counter stops, then loads the upper and lower reload bytes on the next counter-clock tick, then resumes on the tick after that. Each later tick decrements it, and when it reaches zero it sets the ready flag and holds there. A 4-bit command port enters and leaves the mode. Outside the mode, the usual start and stop commands drive the same countdown as a one-shot. Inside the mode, those two commands are ignored.

Top module: `rx_idle_timer`

## Requirements
- R1: After reset, `wdog_flag`, `wdog_irq`, `ct_ready` and `ct_irq` are all low, and the timeout mode is off.
- R2: `wdog_flag` goes high in the cycle after the 64th `bit_tick` counted since the last restart, and not after the 63rd.
- R3: A `char_xfer` or `fifo_rd` pulse restarts the watchdog count from zero and clears `wdog_flag` one cycle later.
- R4: `wdog_irq` is high exactly when `wdog_flag`, `wdog_en` and `fifo_nonempty` are all high.
- R5: A command with `cmd_code` = 4'hA turns timeout mode on, clears `ct_ready` and leaves the counter stopped until the next `char_xfer`.
- R6: In timeout mode, after a `char_xfer`, the first `ct_tick` loads {`reload_hi`,`reload_lo`} (upper byte in bits 15:8) and the second restarts the counter. `ct_ready` then rises after the N-th further tick, where N is the reload value (0 behaves as 1). That is N+2 ticks in total.
- R7: A `char_xfer` during a countdown abandons it and starts the full R6 sequence again.
- R8: Once `ct_ready` is set, further `ct_tick` pulses neither clear it nor restart a count: the counter rests at zero.
- R9: In timeout mode, a `char_xfer` after the timeout fired clears `ct_ready` and `ct_irq` in the next cycle.
- R10: `ct_irq` is high exactly when `ct_ready` and `ct_irq_mask` are both high.
- R11: Command 4'hC turns timeout mode off and stops the counter without changing `ct_ready`. Afterwards, `char_xfer` no longer starts a count.
- R12: Outside timeout mode, command 4'h8 runs the R6 load/start/count sequence and command 4'h9 halts it. Inside timeout mode, both commands are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_tick | input | 1 | One pulse per receive bit time |
| ct_tick | input | 1 | One pulse per counter clock |
| char_xfer | input | 1 | Character moved from shift register into FIFO |
| fifo_rd | input | 1 | FIFO read strobe |
| reload_hi | input | 8 | Upper reload byte |
| reload_lo | input | 8 | Lower reload byte |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 4 | Command code (A on, C off, 8 start, 9 stop) |
| wdog_en | input | 1 | Watchdog interrupt enable |
| ct_irq_mask | input | 1 | Counter-ready interrupt mask bit |
| fifo_nonempty | input | 1 | FIFO holds at least one character |
| wdog_flag | output | 1 | Watchdog expired |
| ct_ready | output | 1 | Timeout counter reached zero |
| wdog_irq | output | 1 | Watchdog interrupt request |
| ct_irq | output | 1 | Counter-ready interrupt request |

## Verification
Two situations are hard to reach from the ports. One is a start or stop command that lands while a timeout-mode countdown is already running. The other is a retrigger arriving partway through a count. To reach them, the bench first arms the mode with 4'hA and sends a character. It then feeds a counted number of counter ticks, so the command or the second character arrives at a known point in the load/start/run sequence. Because the counter value is not visible, the bench confirms that the sequence was undisturbed by finding the exact tick on which `ct_ready` rises.

// File: rtl/rx_idle_pkg.sv
package rx_idle_pkg;
    localparam int CMD_W = 4;
    localparam logic [CMD_W-1:0] CMD_TMO_ON   = 4'hA;
    localparam logic [CMD_W-1:0] CMD_TMO_OFF  = 4'hC;
    localparam logic [CMD_W-1:0] CMD_CT_START = 4'h8;
    localparam logic [CMD_W-1:0] CMD_CT_STOP  = 4'h9;

    typedef enum logic [1:0] {
        TMO_IDLE  = 2'd0,
        TMO_LOAD  = 2'd1,
        TMO_START = 2'd2,
        TMO_RUN   = 2'd3
    } tmo_state_e;
endpackage

// File: rtl/rx_tmo_cmd_dec.sv
module rx_tmo_cmd_dec
    import rx_idle_pkg::*;
(
    input  logic             cmd_valid,
    input  logic [CMD_W-1:0] cmd_code,
    output logic             on_p,
    output logic             off_p,
    output logic             start_p,
    output logic             stop_p
);
    always_comb begin
        on_p    = cmd_valid && (cmd_code == CMD_TMO_ON);
        off_p   = cmd_valid && (cmd_code == CMD_TMO_OFF);
        start_p = cmd_valid && (cmd_code == CMD_CT_START);
        stop_p  = cmd_valid && (cmd_code == CMD_CT_STOP);
    end
endmodule

// File: rtl/rx_wdog.sv
module rx_wdog #(
    parameter int LIMIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_tick,
    input  logic restart,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM_C = CW'(LIMIT);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          exp;
    } wd_s;

    wd_s q, d;

    always_comb begin
        d = q;
        if (restart) begin
            d.cnt = '0;
            d.exp = 1'b0;
        end else if (bit_tick && !q.exp) begin
            if (q.cnt == LIM_C - CW'(1)) begin
                d.cnt = LIM_C;
                d.exp = 1'b1;
            end else begin
                d.cnt = q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign expired = q.exp;

    // R2: count never passes the limit
    a_r2_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= LIM_C);
    // R2: expiry only follows a bit tick
    a_r2_expire_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.exp) |-> $past(bit_tick));
    // R3: restart clears the flag
    a_r3_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (!q.exp && q.cnt == '0));
endmodule

// File: rtl/rx_tmo_ctr.sv
module rx_tmo_ctr
    import rx_idle_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ct_tick,
    input  logic         char_xfer,
    input  logic [W-1:0] reload,
    input  logic         on_p,
    input  logic         off_p,
    input  logic         start_p,
    input  logic         stop_p,
    output logic         ready
);
    typedef struct packed {
        logic [W-1:0] cnt;
        tmo_state_e   st;
        logic         mode;
        logic         rdy;
    } ct_s;

    ct_s q, d;

    always_comb begin
        d = q;
        if (on_p) begin
            d.mode = 1'b1;
            d.rdy  = 1'b0;
            d.st   = TMO_IDLE;
        end else if (off_p) begin
            d.mode = 1'b0;
            d.st   = TMO_IDLE;
        end else if (q.mode && char_xfer) begin
            d.rdy = 1'b0;
            d.st  = TMO_LOAD;
        end else if (!q.mode && start_p) begin
            d.st = TMO_LOAD;
        end else if (!q.mode && stop_p) begin
            d.st = TMO_IDLE;
        end else if (ct_tick) begin
            case (q.st)
                TMO_LOAD: begin
                    d.cnt = reload;
                    d.st  = TMO_START;
                end
                TMO_START: d.st = TMO_RUN;
                TMO_RUN: begin
                    if (q.cnt <= W'(1)) begin
                        d.cnt = '0;
                        d.rdy = 1'b1;
                        d.st  = TMO_IDLE;
                    end else begin
                        d.cnt = q.cnt - W'(1);
                    end
                end
                default: d.st = TMO_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{cnt: '0, st: TMO_IDLE, mode: 1'b0, rdy: 1'b0};
        else        q <= d;
    end

    assign ready = q.rdy;

    // R5: arming clears ready and parks the counter
    a_r5_arm_parks: assert property (@(posedge clk) disable iff (!rst_n)
        on_p |=> (q.st == TMO_IDLE && !q.rdy && q.mode));
    // R6: ready rises only from a running count on a tick
    a_r6_ready_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.rdy) |-> $past(q.st == TMO_RUN && ct_tick));
    // R8: counter rests at zero, never wraps
    a_r8_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (q.cnt == '0 && q.st != TMO_LOAD) |=> q.cnt == '0);
    // R9: ready clears only via char in mode or arm command
    a_r9_ready_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.rdy) |-> $past(on_p || (q.mode && char_xfer)));
    // R12: start command has no effect while in timeout mode
    a_r12_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (q.mode && q.st == TMO_IDLE && !on_p && !off_p && !char_xfer) |=> q.st == TMO_IDLE);
endmodule

// File: rtl/rx_idle_timer.sv
module rx_idle_timer
    import rx_idle_pkg::*;
#(
    parameter int HALF_W     = 8,
    parameter int WDOG_LIMIT = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              ct_tick,
    input  logic              char_xfer,
    input  logic              fifo_rd,
    input  logic [HALF_W-1:0] reload_hi,
    input  logic [HALF_W-1:0] reload_lo,
    input  logic              cmd_valid,
    input  logic [CMD_W-1:0]  cmd_code,
    input  logic              wdog_en,
    input  logic              ct_irq_mask,
    input  logic              fifo_nonempty,
    output logic              wdog_flag,
    output logic              ct_ready,
    output logic              wdog_irq,
    output logic              ct_irq
);
    localparam int CT_W = 2 * HALF_W;

    logic on_p, off_p, start_p, stop_p;

    rx_tmo_cmd_dec u_dec (
        .cmd_valid (cmd_valid),
        .cmd_code  (cmd_code),
        .on_p      (on_p),
        .off_p     (off_p),
        .start_p   (start_p),
        .stop_p    (stop_p)
    );

    rx_wdog #(.LIMIT(WDOG_LIMIT)) u_wdog (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_tick (bit_tick),
        .restart  (char_xfer || fifo_rd),
        .expired  (wdog_flag)
    );

    rx_tmo_ctr #(.W(CT_W)) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .ct_tick   (ct_tick),
        .char_xfer (char_xfer),
        .reload    ({reload_hi, reload_lo}),
        .on_p      (on_p),
        .off_p     (off_p),
        .start_p   (start_p),
        .stop_p    (stop_p),
        .ready     (ct_ready)
    );

    assign wdog_irq = wdog_flag && wdog_en && fifo_nonempty;
    assign ct_irq   = ct_ready && ct_irq_mask;

    // R9: a character in timeout mode leaves no interrupt behind
    a_r9_irq_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (char_xfer && !cmd_valid && $past(on_p)) |=> !ct_irq);
endmodule

// File: tb/rx_idle_timer_tb.sv
module rx_idle_timer_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_tick = 0, ct_tick = 0, char_xfer = 0, fifo_rd = 0;
    logic [7:0] reload_hi = 0, reload_lo = 0;
    logic cmd_valid = 0;
    logic [3:0] cmd_code = 0;
    logic wdog_en = 0, ct_irq_mask = 0, fifo_nonempty = 0;
    logic wdog_flag, ct_ready, wdog_irq, ct_irq;
    int n_chk = 0, n_bad = 0;

    always #5 clk = ~clk;

    rx_idle_timer u_dut (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .ct_tick(ct_tick),
        .char_xfer(char_xfer), .fifo_rd(fifo_rd), .reload_hi(reload_hi),
        .reload_lo(reload_lo), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .wdog_en(wdog_en), .ct_irq_mask(ct_irq_mask), .fifo_nonempty(fifo_nonempty),
        .wdog_flag(wdog_flag), .ct_ready(ct_ready), .wdog_irq(wdog_irq), .ct_irq(ct_irq)
    );

    task automatic check(input logic act, input logic exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic cmd(input logic [3:0] c);
        @(negedge clk); cmd_valid = 1; cmd_code = c;
        @(negedge clk); cmd_valid = 0;
    endtask

    task automatic chr();
        @(negedge clk); char_xfer = 1;
        @(negedge clk); char_xfer = 0;
    endtask

    task automatic ct(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); ct_tick = 1;
            @(negedge clk); ct_tick = 0;
        end
    endtask

    task automatic bt(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); bit_tick = 1;
            @(negedge clk); bit_tick = 0;
        end
    endtask

    task automatic t_reset();
        check(wdog_flag, 0, "R1 wdog_flag");
        check(ct_ready, 0, "R1 ct_ready");
        check(wdog_irq, 0, "R1 wdog_irq");
        check(ct_irq, 0, "R1 ct_irq");
    endtask

    task automatic t_wdog();
        @(negedge clk); fifo_rd = 1; @(negedge clk); fifo_rd = 0;
        bt(63); check(wdog_flag, 0, "R2 after 63");
        bt(1);  check(wdog_flag, 1, "R2 after 64");
        wdog_en = 1; fifo_nonempty = 0; #1; check(wdog_irq, 0, "R4 empty");
        fifo_nonempty = 1; #1; check(wdog_irq, 1, "R4 all set");
        wdog_en = 0; #1; check(wdog_irq, 0, "R4 disabled");
        wdog_en = 1;
        @(negedge clk); fifo_rd = 1; @(negedge clk); fifo_rd = 0;
        check(wdog_flag, 0, "R3 read restart");
        check(wdog_irq, 0, "R3 irq cleared");
        bt(40); chr(); bt(40); check(wdog_flag, 0, "R3 char restart");
        bt(24); check(wdog_flag, 1, "R3 full count after char");
        chr(); check(wdog_flag, 0, "R3 char clears");
    endtask

    task automatic t_timeout();
        reload_hi = 8'h00; reload_lo = 8'h05;
        cmd(4'hA); ct(10); check(ct_ready, 0, "R5 parked after arm");
        chr(); ct(6); check(ct_ready, 0, "R6 before N+2");
        ct(1); check(ct_ready, 1, "R6 at N+2");
        ct_irq_mask = 0; #1; check(ct_irq, 0, "R10 masked");
        ct_irq_mask = 1; #1; check(ct_irq, 1, "R10 unmasked");
        ct(20); check(ct_ready, 1, "R8 held at zero");
        chr(); check(ct_ready, 0, "R9 char clears ready");
        check(ct_irq, 0, "R9 char clears irq");
        ct(5); chr(); ct(6); check(ct_ready, 0, "R7 retrigger not yet");
        ct(1); check(ct_ready, 1, "R7 retrigger fires");
        cmd(4'hA); check(ct_ready, 0, "R5 arm clears ready");
        reload_lo = 8'h00; chr(); ct(2); check(ct_ready, 0, "R6 zero reload early");
        ct(1); check(ct_ready, 1, "R6 zero reload as one");
        reload_hi = 8'h01; reload_lo = 8'h00; chr(); ct(257);
        check(ct_ready, 0, "R6 upper byte early");
        ct(1); check(ct_ready, 1, "R6 upper byte fires");
    endtask

    task automatic t_commands();
        reload_hi = 8'h00; reload_lo = 8'h05;
        cmd(4'hA); cmd(4'h8); ct(20); check(ct_ready, 0, "R12 start ignored in mode");
        chr(); ct(2); cmd(4'h9); ct(4); check(ct_ready, 0, "R12 stop ignored early");
        ct(1); check(ct_ready, 1, "R12 stop ignored fires");
        cmd(4'hC); check(ct_ready, 1, "R11 leave keeps ready");
        cmd(4'hA); cmd(4'hC); chr(); ct(20); check(ct_ready, 0, "R11 char ignored after leave");
        cmd(4'h8); ct(6); check(ct_ready, 0, "R12 one-shot early");
        ct(1); check(ct_ready, 1, "R12 one-shot fires");
        cmd(4'hA); cmd(4'hC); cmd(4'h8); ct(3); cmd(4'h9); ct(20);
        check(ct_ready, 0, "R12 stop halts one-shot");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_wdog();
        t_timeout();
        t_commands();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog timeout actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule